// File: doc/BRIEF.md
# Register Mailbox Read Bridge

This block lets a narrow 16-bit management register port read from a wider internal bus with a 24-bit address space. Software first writes the lower 16 address bits into an address register. It then writes a command word. That word carries the upper 8 address bits in its low byte and an opcode field above them. An opcode of zero asks for a read. The bridge latches the full address and issues one request on the internal bus. It waits as long as the bus needs, keeps the returned word in a data register, and raises a ready flag in the top bit of the command register.

Software normally polls the command register at a coarse interval until the ready flag is set, then reads the data register. A read on the internal side can take a few milliseconds, so a poller typically allows several times that before it gives up. The bridge never times out by itself.

The internal request is a valid/ready channel. `ibus_req_valid` stays high, with `ibus_req_addr` held constant, until the bus raises `ibus_req_ready` in the same cycle. The response channel has no back-pressure. The bridge takes `ibus_rsp_data` in the first cycle after the request handshake in which `ibus_rsp_valid` is high. It ignores `ibus_rsp_valid` at any other time. The management port is plain control: a write strobe with address and data, and a combinational read of the addressed register.

Top module: `mbx_bridge`

## Requirements
- R1: After reset the ready flag, the stored address bytes and the data register all read 0, and `ibus_req_valid` is low.
- R2: The data register sits at offset 5, the low-address register at offset 6 and the command register at offset 7. Every other offset reads 0. A write to any other offset, or to the read-only data register, changes nothing.
- R3: A command write with bits 14:8 equal to zero, made while no access is in flight, starts a read of address {command[7:0], low-address}. Bit 15 of the written word is ignored. In the next cycle `ibus_req_valid` is high and bit 15 of the command register reads 0.
- R4: While `ibus_req_ready` is low, `ibus_req_valid` stays high and `ibus_req_addr` stays stable.
- R5: Each started read produces exactly one request handshake. `ibus_req_valid` is low in the cycle after the handshake.
- R6: When a response arrives after the handshake, the data register takes `ibus_rsp_data` and the command register reads {1, seven zeros, address bits 23:16} from the next cycle on. Before the response arrives, bit 15 stays 0.
- R7: A command write made while an access is in flight has no effect. This holds even in the cycle of the response. The stored high byte, the request address and the result all stay as before, and no second request follows.
- R8: A command write with a non-zero value in bits 14:8 starts nothing. The ready flag and the stored high byte stay unchanged.
- R9: The data register holds its value until the next read completes. It does not change while a new read is pending, and it ignores `ibus_rsp_valid` when no request is awaiting a response.
- R10: A low-address write during an access updates the low-address register, but it does not alter the address of the request already issued.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr_en | input | 1 | Management write strobe |
| reg_addr | input | 5 | Management register offset |
| reg_wdata | input | 16 | Management write data |
| reg_rdata | output | 16 | Contents of the addressed register (combinational) |
| ibus_req_valid | output | 1 | Internal read request valid |
| ibus_req_ready | input | 1 | Internal bus accepts the request |
| ibus_req_addr | output | 24 | Internal read address |
| ibus_rsp_valid | input | 1 | Internal read data valid |
| ibus_rsp_data | input | 16 | Internal read data |

## Verification
Two events can collide in one clock edge: a response arrival that completes the access, and a new command write that would start the next one. The bench places a command write with a different high byte in the exact cycle the response is presented. It then requires that the ready flag rise, that the stored high byte and result belong to the first access, and that no request follow. A second collision is also exercised: low-address and command writes made while a request is stalled under back-pressure. Here the held request address must not move.

// File: rtl/mbx_pkg.sv
`timescale 1ns/1ps
package mbx_pkg;
  typedef enum logic [1:0] {
    SEQ_IDLE  = 2'd0,
    SEQ_ISSUE = 2'd1,
    SEQ_WAIT  = 2'd2
  } seq_state_e;

  localparam int unsigned DEF_OFF_DATA = 5;
  localparam int unsigned DEF_OFF_ALO  = 6;
  localparam int unsigned DEF_OFF_CMD  = 7;
endpackage

// File: rtl/mbx_regs.sv
`timescale 1ns/1ps
// Management-side register file: decode, command acceptance, result hold.
module mbx_regs #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned OFF_DATA = mbx_pkg::DEF_OFF_DATA,
  parameter int unsigned OFF_ALO  = mbx_pkg::DEF_OFF_ALO,
  parameter int unsigned OFF_CMD  = mbx_pkg::DEF_OFF_CMD,
  localparam int unsigned IAW     = HI_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  input  logic              seq_busy,
  input  logic              seq_done,
  input  logic [DATA_W-1:0] seq_data,
  output logic              start,
  output logic [IAW-1:0]    start_addr,
  output logic              ready_o,
  output logic [DATA_W-1:0] data_o
);
  localparam int unsigned RDY_BIT = DATA_W - 1;
  localparam int unsigned OPC_LSB = HI_W;
  localparam int unsigned OPC_MSB = DATA_W - 2;
  localparam logic [REG_AW-1:0] A_DATA = REG_AW'(OFF_DATA);
  localparam logic [REG_AW-1:0] A_ALO  = REG_AW'(OFF_ALO);
  localparam logic [REG_AW-1:0] A_CMD  = REG_AW'(OFF_CMD);

  logic [DATA_W-1:0] alo_q;
  logic [DATA_W-1:0] data_q;
  logic [HI_W-1:0]   ahi_q;
  logic              rdy_q;
  logic              cmd_hit;
  logic              alo_hit;
  logic              opc_read;
  logic [DATA_W-1:0] cmd_view;

  assign cmd_hit    = wr_en && (addr == A_CMD);
  assign alo_hit    = wr_en && (addr == A_ALO);
  assign opc_read   = (wdata[OPC_MSB:OPC_LSB] == '0);
  assign start      = cmd_hit && opc_read && !seq_busy;
  assign start_addr = {wdata[HI_W-1:0], alo_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      alo_q  <= '0;
      ahi_q  <= '0;
      data_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      if (alo_hit) alo_q <= wdata;
      if (start) begin
        ahi_q <= wdata[HI_W-1:0];
        rdy_q <= 1'b0;
      end
      if (seq_done) begin
        data_q <= seq_data;
        rdy_q  <= 1'b1;
      end
    end
  end

  always_comb begin
    cmd_view              = '0;
    cmd_view[HI_W-1:0]    = ahi_q;
    cmd_view[RDY_BIT]     = rdy_q;
  end

  always_comb begin
    unique case (addr)
      A_DATA:  rdata = data_q;
      A_ALO:   rdata = alo_q;
      A_CMD:   rdata = cmd_view;
      default: rdata = '0;
    endcase
  end

  assign ready_o = rdy_q;
  assign data_o  = data_q;
endmodule

// File: rtl/mbx_seq.sv
`timescale 1ns/1ps
// Internal-bus sequencer: one request handshake, then wait for the response.
module mbx_seq #(
  parameter int unsigned IAW    = 24,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [IAW-1:0]    start_addr,
  output logic              req_valid,
  input  logic              req_ready,
  output logic [IAW-1:0]    req_addr,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] done_data
);
  import mbx_pkg::*;

  seq_state_e     state_q, state_d;
  logic [IAW-1:0] addr_q;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      SEQ_IDLE:  if (start)     state_d = SEQ_ISSUE;
      SEQ_ISSUE: if (req_ready) state_d = SEQ_WAIT;
      SEQ_WAIT:  if (rsp_valid) state_d = SEQ_IDLE;
      default:                  state_d = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= SEQ_IDLE;
      addr_q  <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == SEQ_IDLE && start) addr_q <= start_addr;
    end
  end

  assign req_valid = (state_q == SEQ_ISSUE);
  assign req_addr  = addr_q;
  assign busy      = (state_q != SEQ_IDLE);
  assign done      = (state_q == SEQ_WAIT) && rsp_valid;
  assign done_data = rsp_data;
endmodule

// File: rtl/mbx_bridge.sv
`timescale 1ns/1ps
module mbx_bridge #(
  parameter int unsigned REG_AW   = 5,
  parameter int unsigned DATA_W   = 16,
  parameter int unsigned HI_W     = 8,
  parameter int unsigned OFF_DATA = mbx_pkg::DEF_OFF_DATA,
  parameter int unsigned OFF_ALO  = mbx_pkg::DEF_OFF_ALO,
  parameter int unsigned OFF_CMD  = mbx_pkg::DEF_OFF_CMD,
  localparam int unsigned IAW     = HI_W + DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr_en,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              ibus_req_valid,
  input  logic              ibus_req_ready,
  output logic [IAW-1:0]    ibus_req_addr,
  input  logic              ibus_rsp_valid,
  input  logic [DATA_W-1:0] ibus_rsp_data
);
  logic              start_w;
  logic [IAW-1:0]    start_addr_w;
  logic              busy_w;
  logic              done_w;
  logic [DATA_W-1:0] done_data_w;
  logic              ready_w;
  logic [DATA_W-1:0] data_w;

  mbx_regs #(
    .REG_AW(REG_AW), .DATA_W(DATA_W), .HI_W(HI_W),
    .OFF_DATA(OFF_DATA), .OFF_ALO(OFF_ALO), .OFF_CMD(OFF_CMD)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (reg_wr_en),
    .addr      (reg_addr),
    .wdata     (reg_wdata),
    .rdata     (reg_rdata),
    .seq_busy  (busy_w),
    .seq_done  (done_w),
    .seq_data  (done_data_w),
    .start     (start_w),
    .start_addr(start_addr_w),
    .ready_o   (ready_w),
    .data_o    (data_w)
  );

  mbx_seq #(.IAW(IAW), .DATA_W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_w),
    .start_addr(start_addr_w),
    .req_valid (ibus_req_valid),
    .req_ready (ibus_req_ready),
    .req_addr  (ibus_req_addr),
    .rsp_valid (ibus_rsp_valid),
    .rsp_data  (ibus_rsp_data),
    .busy      (busy_w),
    .done      (done_w),
    .done_data (done_data_w)
  );
endmodule

// File: rtl/mbx_bridge_chk.sv
`timescale 1ns/1ps
module mbx_bridge_chk #(
  parameter int unsigned REG_AW  = 5,
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned HI_W    = 8,
  parameter int unsigned OFF_CMD = 7,
  localparam int unsigned IAW    = HI_W + DATA_W
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr_en,
  input logic [REG_AW-1:0] reg_addr,
  input logic [DATA_W-1:0] reg_wdata,
  input logic              ibus_req_valid,
  input logic              ibus_req_ready,
  input logic [IAW-1:0]    ibus_req_addr,
  input logic              start_w,
  input logic              busy_w,
  input logic              done_w,
  input logic              ready_w,
  input logic [DATA_W-1:0] data_w
);
  logic bad_opc_wr;
  assign bad_opc_wr = reg_wr_en && (reg_addr == REG_AW'(OFF_CMD)) &&
                      (reg_wdata[DATA_W-2:HI_W] != '0) && !busy_w;

  a_r3_start_issues: assert property (@(posedge clk) disable iff (!rst_n)
    start_w |=> (ibus_req_valid && !ready_w));

  a_r4_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req_valid && !ibus_req_ready) |=> (ibus_req_valid && $stable(ibus_req_addr)));

  a_r5_single_beat: assert property (@(posedge clk) disable iff (!rst_n)
    (ibus_req_valid && ibus_req_ready) |=> !ibus_req_valid);

  a_r6_done_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    done_w |=> ready_w);

  a_r7_no_start_busy: assert property (@(posedge clk) disable iff (!rst_n)
    busy_w |-> !start_w);

  a_r8_bad_opcode_keeps_ready: assert property (@(posedge clk) disable iff (!rst_n)
    bad_opc_wr |=> $stable(ready_w));

  a_r9_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !done_w |=> $stable(data_w));
endmodule

bind mbx_bridge mbx_bridge_chk #(
  .REG_AW(REG_AW), .DATA_W(DATA_W), .HI_W(HI_W), .OFF_CMD(OFF_CMD)
) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .reg_wr_en     (reg_wr_en),
  .reg_addr      (reg_addr),
  .reg_wdata     (reg_wdata),
  .ibus_req_valid(ibus_req_valid),
  .ibus_req_ready(ibus_req_ready),
  .ibus_req_addr (ibus_req_addr),
  .start_w       (start_w),
  .busy_w        (busy_w),
  .done_w        (done_w),
  .ready_w       (ready_w),
  .data_w        (data_w)
);

// File: tb/mbx_bridge_tb_top.sv
`timescale 1ns/1ps
module mbx_bridge_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [4:0]  reg_addr = '0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        ibus_req_valid;
  logic        ibus_req_ready = 1'b0;
  logic [23:0] ibus_req_addr;
  logic        ibus_rsp_valid = 1'b0;
  logic [15:0] ibus_rsp_data = '0;

  int n_run = 0;
  int n_fail = 0;

  always #2.5 clk = ~clk;

  mbx_bridge dut_i (
    .clk(clk), .rst_n(rst_n),
    .reg_wr_en(reg_wr_en), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ibus_req_valid(ibus_req_valid), .ibus_req_ready(ibus_req_ready),
    .ibus_req_addr(ibus_req_addr),
    .ibus_rsp_valid(ibus_rsp_valid), .ibus_rsp_data(ibus_rsp_data)
  );

  function automatic logic [15:0] mem_word(input logic [7:0] hi, input logic [15:0] lo);
    return lo ^ {hi, hi} ^ 16'h5A3C;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr_en = 1'b1;
    @(negedge clk);
    reg_wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [15:0] d);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic do_read(input logic [7:0] hi, input logic [15:0] lo,
                         input int stall, input int lat);
    logic [15:0] v;
    logic [15:0] prev;
    rd(5'd5, prev);
    wr(5'd6, lo);
    wr(5'd7, {8'h00, hi});
    chk("R3 req_valid after start", {31'd0, ibus_req_valid}, 32'd1);
    chk("R3 req_addr", {8'd0, ibus_req_addr}, {8'd0, hi, lo});
    rd(5'd7, v);
    chk("R3 ready cleared", {31'd0, v[15]}, 32'd0);
    rd(5'd5, v);
    chk("R9 data held while pending", {16'd0, v}, {16'd0, prev});
    for (int s = 0; s < stall; s++) begin
      @(negedge clk);
      chk("R4 req held", {7'd0, ibus_req_valid, ibus_req_addr}, {7'd0, 1'b1, hi, lo});
    end
    ibus_req_ready = 1'b1;
    @(negedge clk);
    ibus_req_ready = 1'b0;
    chk("R5 single handshake", {31'd0, ibus_req_valid}, 32'd0);
    for (int l = 0; l < lat; l++) @(negedge clk);
    rd(5'd7, v);
    chk("R6 not ready before rsp", {31'd0, v[15]}, 32'd0);
    ibus_rsp_valid = 1'b1;
    ibus_rsp_data  = mem_word(hi, lo);
    @(negedge clk);
    ibus_rsp_valid = 1'b0;
    ibus_rsp_data  = 16'hDEAD;
    rd(5'd7, v);
    chk("R6 cmd after completion", {16'd0, v}, {16'd0, 1'b1, 7'd0, hi});
    rd(5'd5, v);
    chk("R6 data captured", {16'd0, v}, {16'd0, mem_word(hi, lo)});
  endtask

  initial begin : watchdog
    #(5.0 * 150000);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin : main
    logic [15:0] v, s5, s6, s7;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 req_valid", {31'd0, ibus_req_valid}, 32'd0);
    rd(5'd5, v); chk("R1 data", {16'd0, v}, 32'd0);
    rd(5'd6, v); chk("R1 addr lo", {16'd0, v}, 32'd0);
    rd(5'd7, v); chk("R1 cmd", {16'd0, v}, 32'd0);

    // Sweep of addresses, stalls and latencies
    for (int h = 0; h < 16; h++) begin
      for (int l = 0; l < 4; l++) begin
        do_read(8'(h * 17), 16'(16'h1234 * (l + 1)) ^ 16'(h), (h + l) % 3, (h * l) % 4);
      end
    end

    // R2 decode: other offsets and read-only data register
    rd(5'd5, s5); rd(5'd6, s6); rd(5'd7, s7);
    for (int a = 0; a < 32; a++) begin
      if (a < 5 || a > 7) begin
        wr(5'(a), 16'hFFFF);
        rd(5'(a), v);
        chk("R2 unmapped reads 0", {16'd0, v}, 32'd0);
      end
    end
    wr(5'd5, 16'h1357);
    rd(5'd5, v); chk("R2 data read-only", {16'd0, v}, {16'd0, s5});
    rd(5'd6, v); chk("R2 addr lo untouched", {16'd0, v}, {16'd0, s6});
    rd(5'd7, v); chk("R2 cmd untouched", {16'd0, v}, {16'd0, s7});
    chk("R2 no request", {31'd0, ibus_req_valid}, 32'd0);

    // R8 non-zero opcodes start nothing
    wr(5'd7, 16'h0155);
    chk("R8 no request op1", {31'd0, ibus_req_valid}, 32'd0);
    wr(5'd7, 16'h7F99);
    chk("R8 no request op7f", {31'd0, ibus_req_valid}, 32'd0);
    rd(5'd7, v); chk("R8 cmd unchanged", {16'd0, v}, {16'd0, s7});

    // R9 stray response while idle
    ibus_rsp_valid = 1'b1; ibus_rsp_data = 16'hA5A5;
    @(negedge clk);
    ibus_rsp_valid = 1'b0;
    rd(5'd5, v); chk("R9 stray rsp ignored", {16'd0, v}, {16'd0, s5});
    rd(5'd7, v); chk("R9 ready kept", {16'd0, v}, {16'd0, s7});

    // R3 bit 15 of the written word is not part of the opcode
    do_read(8'h11, 16'h8000, 1, 1);
    wr(5'd6, 16'h0042);
    wr(5'd7, 16'h8033);
    chk("R3 bit15 ignored start", {8'd0, ibus_req_addr}, {8'd0, 24'h330042});
    ibus_req_ready = 1'b1; @(negedge clk); ibus_req_ready = 1'b0;
    ibus_rsp_valid = 1'b1; ibus_rsp_data = mem_word(8'h33, 16'h0042);
    @(negedge clk); ibus_rsp_valid = 1'b0;
    rd(5'd7, v); chk("R3 bit15 read completes", {16'd0, v}, {16'd0, 16'h8033});

    // R7 / R10: writes while in flight
    wr(5'd6, 16'h1111);
    wr(5'd7, 16'h0022);
    wr(5'd7, 16'h0044);
    wr(5'd6, 16'hBEEF);
    chk("R10 req addr unchanged", {8'd0, ibus_req_addr}, {8'd0, 24'h221111});
    chk("R7 req still pending", {31'd0, ibus_req_valid}, 32'd1);
    rd(5'd6, v); chk("R10 addr lo updated", {16'd0, v}, {16'd0, 16'hBEEF});
    rd(5'd7, v); chk("R7 hi byte kept", {16'd0, v}, {16'd0, 16'h0022});
    ibus_req_ready = 1'b1; @(negedge clk); ibus_req_ready = 1'b0;
    // same-cycle collision: response and command write together
    reg_addr = 5'd7; reg_wdata = 16'h0066; reg_wr_en = 1'b1;
    ibus_rsp_valid = 1'b1; ibus_rsp_data = mem_word(8'h22, 16'h1111);
    @(negedge clk);
    reg_wr_en = 1'b0; ibus_rsp_valid = 1'b0;
    rd(5'd7, v); chk("R7 collision cmd", {16'd0, v}, {16'd0, 16'h8022});
    rd(5'd5, v); chk("R7 collision data", {16'd0, v}, {16'd0, mem_word(8'h22, 16'h1111)});
    @(negedge clk);
    chk("R7 no second request", {31'd0, ibus_req_valid}, 32'd0);
    @(negedge clk);
    chk("R7 still idle", {31'd0, ibus_req_valid}, 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule